// File: doc/BRIEF.md
# Receive Descriptor Ring Pointer Tracker

This block keeps the pointer state of one receive descriptor ring. Software programs the ring length in bytes and moves the tail index as it hands descriptors to the hardware. The receive engine reports how many descriptors it has used with a one-cycle consume pulse. The block holds the head, tail and length registers, and it derives the quantities the receive engine needs from them.

The outputs are combinational views of the registered state. They show whether the ring is usable, whether it has no descriptors to give, how many descriptors are free, and the full 64-bit address of the head descriptor. A low-water pulse marks the cycle in which the free count reaches a programmable multiple of sixteen. Every descriptor is 16 bytes, so the capacity in descriptors is the byte length shifted right by four.

Top module: `rx_ring_tracker`

## Requirements
- R1: `enabled_o` is 1 exactly when the held ring length is nonzero. The capacity in descriptors is the length divided by 16, rounded down.
- R2: `empty_o` is 1 when head equals tail, or when tail is greater than or equal to the capacity. A zero-length ring is therefore always empty.
- R3: `free_o` equals tail minus head when tail is above head. Otherwise it equals capacity minus head plus tail.
- R4: `head_addr_o` equals the 64-bit value {`base_hi_i`,`base_lo_i`} plus 16 times the head index, computed modulo 2^64 with the carry crossing bit 32.
- R5: On a cycle with `consume_i` high, the head becomes head plus `consume_cnt_i`, with the capacity subtracted once if the sum reaches or exceeds it. The new head is visible one cycle later. With no consume and no length write, the head holds its value.
- R6: A consume pulse while the held length is zero leaves the head unchanged.
- R7: A length write loads the new length and clears the head to zero on the next cycle. It takes priority over a consume pulse in the same cycle.
- R8: A tail write loads `tail_data_i` into the tail, and the new value is visible one cycle later.
- R9: `thr_hit_o` is high for one cycle exactly when the free count differs from its value in the previous cycle and equals `thr_i` times 16.
- R10: After reset, head, tail and length are zero. The outputs then read enabled 0, empty 1, free 0 and no threshold pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| base_hi_i | input | 32 | Upper half of the ring base address |
| base_lo_i | input | 32 | Lower half of the ring base address |
| len_wr_i | input | 1 | Length register write strobe |
| len_data_i | input | LEN_W | New ring length in bytes |
| tail_wr_i | input | 1 | Tail register write strobe |
| tail_data_i | input | IDX_W | New tail index |
| thr_i | input | THR_W | Low-water field, scaled by 16 |
| consume_i | input | 1 | Descriptors consumed this cycle |
| consume_cnt_i | input | IDX_W | Number of descriptors consumed |
| enabled_o | output | 1 | Ring length nonzero |
| empty_o | output | 1 | No descriptor available |
| free_o | output | IDX_W+1 | Free descriptor count |
| head_o | output | IDX_W | Current head index |
| head_addr_o | output | 64 | Address of the head descriptor |
| thr_hit_o | output | 1 | Single-cycle low-water event |

## Verification
The bench builds the tracker with LEN_W = 12, which gives IDX_W = 8 and a capacity of up to 255 descriptors. With that size the bench can wrap the head many times in a few hundred cycles and can write tails beyond the capacity. Every low-water target from 0 to 240 also becomes a reachable free count. The base-address pair is chosen so that the head offset carries across bit 32, and the random phase mixes length rewrites with consumes in the same cycle.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int unsigned DESC_SHIFT = 4;  // 16-byte descriptors
  localparam int unsigned THR_SHIFT  = 4;  // threshold field unit: 16 descriptors
  localparam int unsigned BASE_W     = 32;
  localparam int unsigned ADDR_W     = 2 * BASE_W;
endpackage

// File: rtl/rxr_ptr_regs.sv
module rxr_ptr_regs
  import rxr_pkg::*;
#(
  parameter int unsigned LEN_W = 20,
  parameter int unsigned IDX_W = LEN_W - DESC_SHIFT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             len_wr_i,
  input  logic [LEN_W-1:0] len_data_i,
  input  logic             tail_wr_i,
  input  logic [IDX_W-1:0] tail_data_i,
  input  logic             consume_i,
  input  logic [IDX_W-1:0] consume_cnt_i,
  output logic [LEN_W-1:0] len_o,
  output logic [IDX_W-1:0] cap_o,
  output logic [IDX_W-1:0] tail_o,
  output logic [IDX_W-1:0] head_o
);
  logic [LEN_W-1:0] len_q;
  logic [IDX_W-1:0] tail_q, head_q, cap;
  logic [IDX_W:0]   sum;
  logic [IDX_W-1:0] head_adv;

  assign cap = IDX_W'(len_q >> DESC_SHIFT);
  assign sum = {1'b0, head_q} + {1'b0, consume_cnt_i};

  always_comb begin
    if (sum >= {1'b0, cap}) head_adv = IDX_W'(sum - {1'b0, cap});
    else                    head_adv = IDX_W'(sum);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= '0;
      head_q <= '0;
    end else if (len_wr_i) begin
      len_q  <= len_data_i;
      head_q <= '0;
    end else if (consume_i && cap != '0) begin
      head_q <= head_adv;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tail_q <= '0;
    else if (tail_wr_i) tail_q <= tail_data_i;
  end

  assign len_o  = len_q;
  assign cap_o  = cap;
  assign tail_o = tail_q;
  assign head_o = head_q;

  assert_len_clears_head_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_wr_i |=> head_q == '0);
  assert_idle_head_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!len_wr_i && !consume_i) |=> $stable(head_q));
  assert_disabled_no_move_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!len_wr_i && cap == '0) |=> $stable(head_q));
  assert_wrap_in_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!len_wr_i && consume_i && cap != '0 && head_q < cap && consume_cnt_i <= cap)
      |=> head_q < $past(cap));
endmodule

// File: rtl/rxr_ring_status.sv
module rxr_ring_status
  import rxr_pkg::*;
#(
  parameter int unsigned LEN_W = 20,
  parameter int unsigned IDX_W = LEN_W - DESC_SHIFT
) (
  input  logic [BASE_W-1:0] base_hi_i,
  input  logic [BASE_W-1:0] base_lo_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [IDX_W-1:0]  cap_i,
  input  logic [IDX_W-1:0]  tail_i,
  input  logic [IDX_W-1:0]  head_i,
  output logic              enabled_o,
  output logic              empty_o,
  output logic [IDX_W:0]    free_o,
  output logic [ADDR_W-1:0] head_addr_o
);
  logic [IDX_W:0] tail_x, head_x, cap_x;

  assign tail_x = {1'b0, tail_i};
  assign head_x = {1'b0, head_i};
  assign cap_x  = {1'b0, cap_i};

  assign enabled_o = |len_i;
  assign empty_o   = (head_i == tail_i) || (tail_i >= cap_i);

  always_comb begin
    if (tail_i > head_i) free_o = tail_x - head_x;
    else                 free_o = cap_x - head_x + tail_x;
  end

  assign head_addr_o = {base_hi_i, base_lo_i} + (ADDR_W'(head_i) << DESC_SHIFT);
endmodule

// File: rtl/rxr_thr_detect.sv
module rxr_thr_detect
  import rxr_pkg::*;
#(
  parameter int unsigned FREE_W = 17,
  parameter int unsigned THR_W  = 5,
  parameter int unsigned CMP_W  = (FREE_W > THR_W + THR_SHIFT) ? FREE_W : THR_W + THR_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FREE_W-1:0] free_i,
  input  logic [THR_W-1:0]  thr_i,
  output logic              hit_o
);
  logic [FREE_W-1:0] free_q;
  logic [CMP_W-1:0]  target;

  assign target = CMP_W'(thr_i) << THR_SHIFT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) free_q <= '0;
    else         free_q <= free_i;
  end

  assign hit_o = (free_i != free_q) && (CMP_W'(free_i) == target);
endmodule

// File: rtl/rx_ring_tracker.sv
module rx_ring_tracker
  import rxr_pkg::*;
#(
  parameter int unsigned LEN_W = 20,
  parameter int unsigned THR_W = 5,
  parameter int unsigned IDX_W = LEN_W - DESC_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       base_hi_i,
  input  logic [31:0]       base_lo_i,
  input  logic              len_wr_i,
  input  logic [LEN_W-1:0]  len_data_i,
  input  logic              tail_wr_i,
  input  logic [IDX_W-1:0]  tail_data_i,
  input  logic [THR_W-1:0]  thr_i,
  input  logic              consume_i,
  input  logic [IDX_W-1:0]  consume_cnt_i,
  output logic              enabled_o,
  output logic              empty_o,
  output logic [IDX_W:0]    free_o,
  output logic [IDX_W-1:0]  head_o,
  output logic [63:0]       head_addr_o,
  output logic              thr_hit_o
);
  localparam int unsigned FREE_W = IDX_W + 1;

  logic [LEN_W-1:0] len;
  logic [IDX_W-1:0] cap, tail, head;

  rxr_ptr_regs #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_regs (
    .clk_i, .rst_ni, .len_wr_i, .len_data_i, .tail_wr_i, .tail_data_i,
    .consume_i, .consume_cnt_i,
    .len_o(len), .cap_o(cap), .tail_o(tail), .head_o(head)
  );

  rxr_ring_status #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_status (
    .base_hi_i, .base_lo_i, .len_i(len), .cap_i(cap), .tail_i(tail), .head_i(head),
    .enabled_o, .empty_o, .free_o, .head_addr_o
  );

  rxr_thr_detect #(.FREE_W(FREE_W), .THR_W(THR_W)) u_thr (
    .clk_i, .rst_ni, .free_i(free_o), .thr_i, .hit_o(thr_hit_o)
  );

  assign head_o = head;

  assert_free_below_cap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty_o |-> free_o < {1'b0, cap});
  assert_disabled_empty_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enabled_o |-> empty_o);
  assert_pulse_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_hit_o |=> (!thr_hit_o || !$stable(thr_i)));
endmodule

// File: tb/sim_rx_ring_tracker.sv
module sim_rx_ring_tracker;
  localparam int LEN_W = 12;
  localparam int THR_W = 5;
  localparam int IDX_W = LEN_W - 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] base_hi = '0, base_lo = '0;
  logic len_wr = 1'b0, tail_wr = 1'b0, consume = 1'b0;
  logic [LEN_W-1:0] len_d = '0;
  logic [IDX_W-1:0] tail_d = '0, cnt = '0;
  logic [THR_W-1:0] thr = '0;
  logic enabled, empty, hit;
  logic [IDX_W:0] free;
  logic [IDX_W-1:0] head;
  logic [63:0] addr;

  int checks = 0, errors = 0;
  int m_len = 0, m_head = 0, m_tail = 0, m_prev = 0;

  always #2 clk = ~clk;

  rx_ring_tracker #(.LEN_W(LEN_W), .THR_W(THR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .base_hi_i(base_hi), .base_lo_i(base_lo),
    .len_wr_i(len_wr), .len_data_i(len_d), .tail_wr_i(tail_wr), .tail_data_i(tail_d),
    .thr_i(thr), .consume_i(consume), .consume_cnt_i(cnt),
    .enabled_o(enabled), .empty_o(empty), .free_o(free), .head_o(head),
    .head_addr_o(addr), .thr_hit_o(hit)
  );

  function automatic int m_cap();
    return m_len / 16;
  endfunction

  function automatic int m_free();
    if (m_tail > m_head) return m_tail - m_head;
    return m_cap() - m_head + m_tail;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_len = 0; m_head = 0; m_tail = 0; m_prev = 0;
    end else begin
      int c;
      c = m_cap();
      m_prev = m_free();
      if (len_wr) begin
        m_len = int'(len_d); m_head = 0;
      end else if (consume && c > 0) begin
        m_head = m_head + int'(cnt);
        if (m_head >= c) m_head = m_head - c;
      end
      if (tail_wr) m_tail = int'(tail_d);
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [63:0] ea;
    int f;
    f = m_free();
    ea = {base_hi, base_lo} + 64'(m_head * 16);
    chk("R1 enabled", longint'(enabled), longint'(m_len != 0));
    chk("R2 empty", longint'(empty), longint'(m_head == m_tail || m_tail >= m_cap()));
    chk("R3 free", longint'(free), longint'(f));
    chk("R5 head", longint'(head), longint'(m_head));
    chk("R4 addr", longint'(addr), longint'(ea));
    chk("R9 hit", longint'(hit), longint'(f != m_prev && f == int'(thr) * 16));
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    len_wr = 1'b0; tail_wr = 1'b0; consume = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 enabled", longint'(enabled), 0);
    chk("R10 empty", longint'(empty), 1);
    chk("R10 free", longint'(free), 0);
    chk("R10 hit", longint'(hit), 0);
    rst_n = 1'b1;
    step();
    // R6: consume on zero-length ring
    consume = 1'b1; cnt = 8'd5; step();
    chk("R6 head", longint'(head), 0);
    // R1/R8: enable with 64 descriptors, tail write
    base_hi = 32'h1; base_lo = 32'hFFFF_FFF0;
    len_wr = 1'b1; len_d = 12'd1024; step();
    chk("R1 enabled", longint'(enabled), 1);
    thr = 5'd2;
    tail_wr = 1'b1; tail_d = 8'd40; step();
    chk("R8 free", longint'(free), 40);
    // R9: free 40 -> 32 matches 2*16
    consume = 1'b1; cnt = 8'd8; step();
    chk("R9 pulse", longint'(hit), 1);
    step();
    chk("R9 single", longint'(hit), 0);
    // R3/R5: wraparound
    tail_wr = 1'b1; tail_d = 8'd5; step();
    chk("R3 wrap free", longint'(free), 61);
    consume = 1'b1; cnt = 8'd60; step();
    chk("R5 wrap head", longint'(head), 4);
    chk("R4 carry addr", longint'(addr), 64'h2_0000_0030);
    // R2: tail beyond capacity
    tail_wr = 1'b1; tail_d = 8'd70; step();
    chk("R2 oob empty", longint'(empty), 1);
    // R7: length write wins over consume
    len_wr = 1'b1; len_d = 12'd512; consume = 1'b1; cnt = 8'd3; step();
    chk("R7 head", longint'(head), 0);
    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      int c;
      c = m_cap();
      if ($urandom_range(0, 19) == 0) begin
        len_wr = 1'b1; len_d = LEN_W'($urandom_range(0, 4095));
      end
      if ($urandom_range(0, 3) == 0) begin
        tail_wr = 1'b1; tail_d = IDX_W'($urandom_range(0, 255));
      end
      if ($urandom_range(0, 1) == 0) begin
        consume = 1'b1; cnt = IDX_W'($urandom_range(0, c));
      end
      if ($urandom_range(0, 29) == 0) thr = THR_W'($urandom_range(0, 15));
      step();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule